// File: doc/BRIEF.md
# Receive Byte Queue with Break Insertion

This block holds up to four received bytes between the serial line side of a UART and its register interface. The line side offers bytes through a valid/data pair and is told, through an accept-ready output, when a byte may be delivered. A separate line monitor signals a break condition. A break stores a zero byte and raises a break interrupt flag, which stays raised until software clears it.

The register side takes bytes with a single-cycle pop request. The oldest byte is presented on the read data output at all times, and reads as zero when the queue is empty. Two registered status flags give the register side its view of the queue: one says that at least one byte is waiting, the other says that all four slots are taken. A flush request empties the queue. When a break arrives while the queue is full, the newest stored byte is replaced instead of the break being lost.

Top module: `rx_hold_queue`

## Requirements
- R1: After reset the queue is empty and `rx_ready`, `fifo_full` and `brk_flag` are low. `rx_ready` is high whenever one to four bytes are held, and `fifo_full` is high exactly when four bytes are held. Both flags are registered and change in the cycle after the event that causes the change.
- R2: A push into a full queue replaces the most recently stored byte. The three older bytes are kept and the count stays at four. With the line gating of R6 in place, only a break can push into a full queue.
- R3: Every accepted push sets `rx_ready` in the following cycle.
- R4: `pop_data` always shows the oldest held byte, combinationally. A `pop` in a cycle with bytes held removes that byte. Afterwards `fifo_full` is low, and `rx_ready` is low only if the queue became empty.
- R5: `pop_data` is 0x00 while the queue is empty. A `pop` while the queue is empty changes no state.
- R6: `line_accept` equals `rx_en` AND NOT `fifo_full`. A `line_valid` byte is stored only in a cycle where `line_accept` is high; otherwise it is ignored.
- R7: A `brk_evt` pushes a 0x00 byte whether or not the receiver is enabled, and in that cycle it takes precedence over a line byte, which is then dropped. It also sets `brk_flag`, which stays high until a cycle with `clr_brk` and no `brk_evt`. If both arrive in the same cycle, the set wins.
- R8: `flush` empties the queue and clears `rx_ready` and `fifo_full` in the next cycle. It overrides any push or pop in the same cycle, but a break in that cycle still sets `brk_flag`.
- R9: When a pop and a push fall in the same cycle, the pop is applied first. A full queue therefore stores the new byte at its tail without replacing anything, and stays full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; gates line bytes |
| flush | input | 1 | Empty the queue |
| clr_brk | input | 1 | Clear the break interrupt flag |
| line_valid | input | 1 | Line side offers a byte this cycle |
| line_data | input | 8 | Byte offered by the line side |
| brk_evt | input | 1 | Break detected on the line; inserts a zero byte |
| pop | input | 1 | Register side takes the oldest byte |
| pop_data | output | 8 | Oldest held byte, 0x00 when empty |
| rx_ready | output | 1 | At least one byte held |
| fifo_full | output | 1 | Four bytes held |
| brk_flag | output | 1 | Break interrupt flag |
| line_accept | output | 1 | Line side may deliver a byte |

## Verification
Several pairs of functions can fall in one cycle: a pop and a push, a break and a line byte, a break and a clear-break, and a flush with any of the others. The pair that matters most is a pop together with a push. When the queue is full, that pair must store the incoming byte at the tail and must not overwrite the newest entry. The bench fills the queue and then issues a break together with a pop. It then drains the queue and compares the whole order of the bytes against a reference model in the bench. A long pseudo-random sweep also lands pops, line bytes, breaks and flushes in the same cycles at every fill level, and every cycle is judged against that model.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_LINE  = 2'd1,
    SRC_BREAK = 2'd2
  } push_src_e;

  function automatic int unsigned ring_next(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  function automatic int unsigned ring_prev(int unsigned p, int unsigned depth);
    return (p == 0) ? depth - 1 : p - 1;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              pop,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  output logic [DATA_W-1:0] head_data,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  next_count,
  output logic              pop_taken,
  output logic              overwrite
);
  import rxq_pkg::*;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr, wr_slot;
  logic [CNT_W-1:0]  after_pop;
  logic              push_taken;

  assign pop_taken  = pop && (count != '0) && !flush;
  assign push_taken = push && !flush;
  assign after_pop  = count - CNT_W'(pop_taken);
  assign overwrite  = push_taken && (after_pop == CNT_W'(DEPTH));
  assign wr_slot    = overwrite ? PTR_W'(ring_prev(32'(wr_ptr), DEPTH)) : wr_ptr;
  assign next_count = flush ? '0 : after_pop + CNT_W'(push_taken && !overwrite);
  assign head_data  = (count == '0) ? '0 : mem[rd_ptr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic wen;
    assign wen = push_taken && (wr_slot == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (wen) mem[i] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      count <= next_count;
      if (flush) begin
        rd_ptr <= '0;
        wr_ptr <= '0;
      end else begin
        if (pop_taken) rd_ptr <= PTR_W'(ring_next(32'(rd_ptr), DEPTH));
        if (push_taken && !overwrite) wr_ptr <= PTR_W'(ring_next(32'(wr_ptr), DEPTH));
      end
    end
  end

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  assert_overwrite_keeps_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    overwrite |=> (count == CNT_W'(DEPTH)));

  assert_empty_pop_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && count == '0 && !push && !flush) |=> (count == '0 && $stable(rd_ptr)));

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] next_count,
  output logic             ready,
  output logic             full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b0;
      full  <= 1'b0;
    end else begin
      ready <= (next_count != '0);
      full  <= (next_count == CNT_W'(DEPTH));
    end
  end
endmodule

// File: rtl/rxq_brk_flag.sv
module rxq_brk_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

  assert_brk_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag);
endmodule

// File: rtl/rx_hold_queue.sv
module rx_hold_queue #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              flush,
  input  logic              clr_brk,
  input  logic              line_valid,
  input  logic [DATA_W-1:0] line_data,
  input  logic              brk_evt,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic              rx_ready,
  output logic              fifo_full,
  output logic              brk_flag,
  output logic              line_accept
);
  import rxq_pkg::*;

  push_src_e         src;
  logic              push;
  logic [DATA_W-1:0] push_data;
  logic [CNT_W-1:0]  count, next_count;
  logic              pop_taken, overwrite;

  assign line_accept = rx_en && !fifo_full;

  always_comb begin
    if (brk_evt)                        src = SRC_BREAK;
    else if (line_valid && line_accept) src = SRC_LINE;
    else                                src = SRC_NONE;
  end

  assign push      = (src != SRC_NONE);
  assign push_data = (src == SRC_BREAK) ? '0 : line_data;

  rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pop(pop), .push(push),
    .push_data(push_data), .head_data(pop_data), .count(count),
    .next_count(next_count), .pop_taken(pop_taken), .overwrite(overwrite)
  );

  rxq_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .next_count(next_count),
    .ready(rx_ready), .full(fifo_full)
  );

  rxq_brk_flag u_brk (
    .clk(clk), .rst_n(rst_n), .set_evt(brk_evt), .clr_req(clr_brk), .flag(brk_flag)
  );

  assert_full_tracks_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full == (count == CNT_W'(DEPTH)));

  assert_push_sets_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush) |=> rx_ready);

  assert_pop_clears_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_taken && src == SRC_NONE) |=> !fifo_full);

  assert_empty_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> (pop_data == '0));

  assert_no_line_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !line_accept);

  assert_brk_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> brk_flag);

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!rx_ready && !fifo_full));

  assert_pop_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_taken && push) |-> !overwrite);

endmodule

// File: tb/rx_hold_queue_tb.sv
module rx_hold_queue_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0, flush = 1'b0, clr_brk = 1'b0;
  logic       line_valid = 1'b0, brk_evt = 1'b0, pop = 1'b0;
  logic [7:0] line_data = 8'h00;
  logic [7:0] pop_data;
  logic       rx_ready, fifo_full, brk_flag, line_accept;

  int checks = 0;
  int fails  = 0;

  logic [7:0] mq [4];
  int         mcnt = 0;
  logic       mbrk = 1'b0;

  always #2.5 clk = ~clk;

  rx_hold_queue u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .flush(flush), .clr_brk(clr_brk),
    .line_valid(line_valid), .line_data(line_data), .brk_evt(brk_evt), .pop(pop),
    .pop_data(pop_data), .rx_ready(rx_ready), .fifo_full(fifo_full),
    .brk_flag(brk_flag), .line_accept(line_accept)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(input logic e, input logic f, input logic cb,
                            input logic lv, input logic [7:0] ld,
                            input logic be, input logic p);
    logic       psh;
    logic [7:0] d;
    psh = be || (lv && e && (mcnt != 4));
    d   = be ? 8'h00 : ld;
    if (f) mcnt = 0;
    else begin
      if (p && mcnt > 0) begin
        for (int i = 0; i < 3; i++) mq[i] = mq[i+1];
        mcnt--;
      end
      if (psh) begin
        if (mcnt == 4) mq[3] = d;
        else begin mq[mcnt] = d; mcnt++; end
      end
    end
    if (be) mbrk = 1'b1;
    else if (cb) mbrk = 1'b0;
  endtask

  task automatic step(input string tag, input logic e, input logic f, input logic cb,
                      input logic lv, input logic [7:0] ld,
                      input logic be, input logic p);
    @(negedge clk);
    rx_en = e; flush = f; clr_brk = cb; line_valid = lv; line_data = ld;
    brk_evt = be; pop = p;
    #1;
    check({tag, " R4/R5 pop_data"}, pop_data, (mcnt == 0) ? 0 : mq[0]);
    check({tag, " R6 line_accept"}, line_accept, e && (mcnt != 4));
    model_step(e, f, cb, lv, ld, be, p);
    @(posedge clk);
    #1;
    check({tag, " R1 rx_ready"}, rx_ready, mcnt != 0);
    check({tag, " R1 fifo_full"}, fifo_full, mcnt == 4);
    check({tag, " R7 brk_flag"}, brk_flag, mbrk);
  endtask

  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    #12;
    check("R1 reset rx_ready", rx_ready, 0);
    check("R1 reset fifo_full", fifo_full, 0);
    check("R1 reset brk_flag", brk_flag, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 5; i++) step("R1 R3 R6 fill", 1, 0, 0, 1, 8'h10 + 8'(i), 0, 0);
    step("R6 disabled ignored", 0, 0, 0, 1, 8'h77, 0, 0);

    step("R2 break overwrite", 1, 0, 0, 0, 8'h00, 1, 0);
    check("R2 head kept", pop_data, 8'h10);
    for (int i = 0; i < 4; i++) step("R2 R4 drain", 1, 0, 0, 0, 8'h00, 0, 1);

    step("R5 empty pop", 1, 0, 0, 0, 8'h00, 0, 1);
    check("R5 empty data", pop_data, 0);

    step("R7 clear", 1, 0, 1, 0, 8'h00, 0, 0);
    step("R7 set wins", 0, 0, 1, 1, 8'h55, 1, 0);
    step("R7 clear again", 0, 0, 1, 0, 8'h00, 0, 0);

    for (int i = 0; i < 4; i++) step("R9 prefill", 1, 0, 0, 1, 8'hA0 + 8'(i), 0, 0);
    step("R9 pop with break", 1, 0, 0, 0, 8'h00, 1, 1);
    for (int i = 0; i < 4; i++) step("R9 drain", 1, 0, 0, 0, 8'h00, 0, 1);
    step("R9 empty pop+push", 1, 0, 0, 1, 8'h3C, 0, 1);

    step("R8 flush with push", 1, 1, 0, 1, 8'h99, 1, 1);
    check("R8 empty after flush", pop_data, 0);

    for (int n = 0; n < 4000; n++) begin
      logic [15:0] r;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = lfsr;
      step("sweep", r[0] | r[1], (r[7:3] == 5'd0), (r[10:8] == 3'd0),
           r[2] | r[11], {r[15:12], r[3:0]}, (r[14:11] == 4'd5), r[13] & r[4]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule